// File: doc/BRIEF.md
# Receive Byte Queue with Hysteretic Drain Alarm

This block buffers bytes arriving from a link into a 128-entry queue and tells the draining side when to act. A write port accepts one byte per clock from the link; the drain side sees the oldest byte on its read data output at all times and removes it with a read strobe. Two live levels, empty and alarm, are registered one clock behind the occupancy so that they are glitch-free and easy to time.

The alarm raises when the occupancy reaches a programmable watermark and then holds, giving hysteresis, until one of two release points is met: the queue becomes empty, or the occupancy climbs so high that fewer bytes of free space remain than a 3-bit granularity setting. Error conditions collect in a sticky status word. Each condition has its own mask bit, and the error output is high while any unmasked condition is pending. A small register port gives software access to the control word, the status word and the watermark.

Top module: `rxq_alarm_fifo`

## Requirements
- R1: The queue holds up to 128 bytes and returns them in write order; `rd_data` always shows the oldest stored byte, and shows 0 while the queue is empty.
- R2: `empty_o` resets to 1 and, one clock after any occupancy change, equals 1 exactly when the queue holds no bytes.
- R3: The watermark register (address 2, 12 bits, reset value 64) and granularity (control bits [2:0]) drive `alarm_o`, which updates one clock after the occupancy: it drops if the queue is empty or if occupancy + granularity > 128; otherwise it rises if occupancy >= watermark; otherwise it keeps its value.
- R4: A granularity larger than 128 minus the watermark is not guarded: at occupancy equal to the watermark the release condition wins and `alarm_o` stays low.
- R5: `err_o` is high while any status bit [5:0] is 1 and its mask bit (control bit 8+i for status bit i) is 0.
- R6: A write while 128 bytes are stored is discarded without changing the stored bytes or the occupancy, and sets sticky overflow status bit 4; a read in the same cycle still removes a byte.
- R7: A read while the queue is empty sets sticky underflow status bit 3 and moves nothing.
- R8: Status bits [5:0] (0 illegal pointer, 1 frame accept error, 2 receive wait, 3 underflow, 4 overflow, 5 transmit wait) are sticky; writing 1 to a bit at address 1 clears it, a new event in the same cycle wins; `link_flags` bits 0..3 set status bits 0, 1, 2 and 5. Status bits 8 and 9 read the live empty and alarm levels.
- R9: The control word (address 0) resets to 0x0000_2401 (granularity 1, receive-wait and transmit-wait masks set); only bits [2:0], [13:8] and 16 are writable, all others read 0.
- R10: Control bit 16 (frame marker) is stored and read back but changes nothing in queue behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_data | input | 8 | Byte from the link |
| rd_en | input | 1 | Remove the oldest byte this cycle |
| rd_data | output | 8 | Oldest stored byte |
| link_flags | input | 4 | One-cycle event pulses from the link side |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 watermark |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| empty_o | output | 1 | Registered empty level |
| alarm_o | output | 1 | Registered alarm level |
| err_o | output | 1 | Any unmasked sticky error pending |

## Verification
The checker assumes the reset is held for at least one clock before any stimulus and that `link_flags` and the register port are driven with settled values at every sampled edge. The bench drives every input on the falling edge and holds reset low over several edges, so the properties see clean values. The release assertion further assumes the granularity is only changed through the register port, which the bench does only while the queue is idle.

// File: rtl/rxq_pkg.sv
// Package: shared field positions, register selects and the control record
// for the receive byte queue. Assumes a 32-bit register port.
package rxq_pkg;
    localparam int REG_W     = 32;
    localparam int GRAN_W    = 3;
    localparam int MARK_W    = 12;
    localparam int NSRC      = 6;

    // Register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STS  = 2'd1;
    localparam logic [1:0] SEL_MARK = 2'd2;

    // Status bit positions; mask for status bit i lives at MASK_LSB + i
    localparam int ST_IP    = 0;
    localparam int ST_FAE   = 1;
    localparam int ST_RXW   = 2;
    localparam int ST_UF    = 3;
    localparam int ST_OF    = 4;
    localparam int ST_TXW   = 5;
    localparam int ST_EMPTY = 8;
    localparam int ST_ALARM = 9;

    localparam int MASK_LSB  = 8;
    localparam int FRAME_BIT = 16;

    localparam logic [MARK_W-1:0] MARK_RST = 12'd64;

    typedef struct packed {
        logic              frame_mark;
        logic [NSRC-1:0]   mask;
        logic [GRAN_W-1:0] gran;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{frame_mark: 1'b0,
                                   mask: 6'b100100,
                                   gran: 3'd1};
endpackage

// File: rtl/rxq_store.sv
// Module: byte storage with read/write pointers and an occupancy count.
// Assumes DEPTH is a power of two so pointers wrap naturally. A write while
// full and a read while empty are dropped and reported as one-cycle events.
module rxq_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     fill,
    output logic              ovf_evt,
    output logic              udf_evt
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic              full;
    logic              none;
    logic              do_wr;
    logic              do_rd;

    // Decide which requests are accepted this cycle from the current fill.
    always_comb begin
        full    = (fill == CW'(DEPTH));
        none    = (fill == '0);
        do_wr   = wr_en && !full;
        do_rd   = rd_en && !none;
        ovf_evt = wr_en && full;
        udf_evt = rd_en && none;
    end

    // Store accepted bytes; storage carries no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Advance pointers and occupancy for accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Show the oldest byte, or zero when nothing is stored.
    always_comb begin
        rd_data = none ? '0 : mem[rptr];
    end
endmodule

// File: rtl/rxq_level.sv
// Module: registered empty and alarm levels derived from the occupancy.
// Alarm rises at the watermark and is released on empty or when free space
// drops below the granularity; release has priority and is not guarded.
module rxq_level #(
    parameter int DEPTH  = 128,
    parameter int GRAN_W = 3,
    parameter int MARK_W = 12,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int SW    = (MARK_W > CW + 1) ? MARK_W : CW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     fill,
    input  logic [MARK_W-1:0] mark,
    input  logic [GRAN_W-1:0] gran,
    output logic              empty_q,
    output logic              alarm_q
);
    logic [SW-1:0] fill_x;
    logic [SW-1:0] top_x;
    logic          hit_mark;
    logic          hit_ceiling;
    logic          is_empty;
    logic          alarm_d;

    // Compare in a common width so a large watermark never aliases.
    always_comb begin
        fill_x      = SW'(fill);
        top_x       = fill_x + SW'(gran);
        is_empty    = (fill == '0);
        hit_mark    = (fill_x >= SW'(mark));
        hit_ceiling = (top_x > SW'(DEPTH));
        if (is_empty || hit_ceiling) alarm_d = 1'b0;
        else if (hit_mark)           alarm_d = 1'b1;
        else                         alarm_d = alarm_q;
    end

    // Register both levels one clock behind the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            alarm_q <= 1'b0;
        end else begin
            empty_q <= is_empty;
            alarm_q <= alarm_d;
        end
    end
endmodule

// File: rtl/rxq_regs.sv
// Module: control word, sticky status word and watermark behind a simple
// register port, plus the masked error combine. Reads are combinational.
// Assumes one register access per cycle; event set wins over clear.
module rxq_regs
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [3:0]        link_flags,
    input  logic              ovf_evt,
    input  logic              udf_evt,
    input  logic              empty_lvl,
    input  logic              alarm_lvl,
    output ctrl_t             ctrl,
    output logic [NSRC-1:0]   sticky,
    output logic [MARK_W-1:0] mark,
    output logic              err_o
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] pend;

    // Gather this cycle's error events into status bit order.
    always_comb begin
        set_vec         = '0;
        set_vec[ST_IP]  = link_flags[0];
        set_vec[ST_FAE] = link_flags[1];
        set_vec[ST_RXW] = link_flags[2];
        set_vec[ST_TXW] = link_flags[3];
        set_vec[ST_UF]  = udf_evt;
        set_vec[ST_OF]  = ovf_evt;
        clr_vec = (reg_we && reg_addr == SEL_STS) ? reg_wdata[NSRC-1:0] : '0;
    end

    // Hold the writable control fields; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else if (reg_we && reg_addr == SEL_CTRL) begin
            ctrl.gran       <= reg_wdata[GRAN_W-1:0];
            ctrl.mask       <= reg_wdata[MASK_LSB +: NSRC];
            ctrl.frame_mark <= reg_wdata[FRAME_BIT];
        end
    end

    // Hold the alarm watermark.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  mark <= MARK_RST;
        else if (reg_we && reg_addr == SEL_MARK)     mark <= reg_wdata[MARK_W-1:0];
    end

    // Sticky status bits: write-one-to-clear, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~clr_vec) | set_vec;
    end

    // One error source per bit passes only when unmasked.
    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign pend[i] = sticky[i] & ~ctrl.mask[i];
    end

    // Combine pending sources into the error output.
    always_comb begin
        err_o = |pend;
    end

    // Return the selected register with reserved bits at zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTRL: begin
                reg_rdata[GRAN_W-1:0]        = ctrl.gran;
                reg_rdata[MASK_LSB +: NSRC]  = ctrl.mask;
                reg_rdata[FRAME_BIT]         = ctrl.frame_mark;
            end
            SEL_STS: begin
                reg_rdata[NSRC-1:0] = sticky;
                reg_rdata[ST_EMPTY] = empty_lvl;
                reg_rdata[ST_ALARM] = alarm_lvl;
            end
            SEL_MARK: reg_rdata[MARK_W-1:0] = mark;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxq_alarm_fifo.sv
// Module: top of the receive byte queue. Joins storage, level generation and
// the register block. Assumes a single clock and synchronous active-low reset.
module rxq_alarm_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [3:0]        link_flags,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              empty_o,
    output logic              alarm_o,
    output logic              err_o
);
    logic [CW-1:0]     fill_w;
    logic              ovf_w;
    logic              udf_w;
    ctrl_t             ctrl_w;
    logic [NSRC-1:0]   sts_w;
    logic [MARK_W-1:0] mark_w;

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .fill    (fill_w),
        .ovf_evt (ovf_w),
        .udf_evt (udf_w)
    );

    rxq_level #(.DEPTH(DEPTH), .GRAN_W(GRAN_W), .MARK_W(MARK_W)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill    (fill_w),
        .mark    (mark_w),
        .gran    (ctrl_w.gran),
        .empty_q (empty_o),
        .alarm_q (alarm_o)
    );

    rxq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .link_flags (link_flags),
        .ovf_evt    (ovf_w),
        .udf_evt    (udf_w),
        .empty_lvl  (empty_o),
        .alarm_lvl  (alarm_o),
        .ctrl       (ctrl_w),
        .sticky     (sts_w),
        .mark       (mark_w),
        .err_o      (err_o)
    );
endmodule

// File: rtl/rxq_alarm_fifo_chk.sv
// Module: property checker for the receive byte queue, bound to the top.
// Assumes reset is held for at least one clock before stimulus.
module rxq_alarm_fifo_chk #(
    parameter int DEPTH  = 128,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          empty_o,
    input logic          alarm_o,
    input logic          err_o,
    input logic [CW-1:0] fill,
    input logic [5:0]    sticky,
    input logic [5:0]    mask,
    input logic [2:0]    gran
);
    // R6: occupancy never exceeds the capacity
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R2: empty level follows the previous cycle's occupancy
    a_r2_empty_lags: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (empty_o == $past(fill == '0)));

    // R6: a write while full leaves the overflow bit set
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill == CW'(DEPTH)) |=> sticky[4]);

    // R7: a read while empty leaves the underflow bit set, nothing moves without a write
    a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && fill == '0) |=> (sticky[3] && fill == '0));

    // R5: fully masked sources never raise the error output
    a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !err_o);

    // R3: past the ceiling the alarm is low on the next clock
    a_r3_alarm_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(fill) + 32'(gran)) > DEPTH || fill == '0) |=> !alarm_o);
endmodule

bind rxq_alarm_fifo rxq_alarm_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .empty_o (empty_o),
    .alarm_o (alarm_o),
    .err_o   (err_o),
    .fill    (fill_w),
    .sticky  (sts_w),
    .mask    (ctrl_w.mask),
    .gran    (ctrl_w.gran)
);

// File: tb/sim_rxq_alarm_fifo.sv
module sim_rxq_alarm_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  link_flags = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        empty_o, alarm_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxq_alarm_fifo u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        b = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R2 empty at reset", empty_o, 1);
        chk("R3 alarm at reset", alarm_o, 0);
        chk("R5 err at reset", err_o, 0);
        rreg(2'd0, v); chk("R9 ctrl reset", v, 32'h0000_2401);
        rreg(2'd2, v); chk("R3 mark reset", v, 64);
        rreg(2'd1, v); chk("R8 status reset", v, 32'h100);
    endtask

    task automatic t_alarm();
        logic [7:0] b;
        wreg(2'd2, 4);
        for (int i = 0; i < 3; i++) push(8'(i));
        chk("R2 empty one clock late", empty_o, 0);
        idle(); chk("R3 below mark", alarm_o, 0);
        push(8'd3);
        chk("R3 not yet registered", alarm_o, 0);
        idle(); chk("R3 at mark", alarm_o, 1);
        for (int i = 4; i < 127; i++) push(8'(i));
        idle(); chk("R3 below ceiling", alarm_o, 1);
        push(8'd127);
        idle(); chk("R3 released at ceiling", alarm_o, 0);
        pop(b); chk("R1 order head", b, 0);
        idle(); chk("R3 reasserts", alarm_o, 1);
        for (int i = 1; i < 127; i++) begin
            pop(b);
            chk("R1 order", b, 32'(i));
        end
        idle(); chk("R3 hysteresis hold below mark", alarm_o, 1);
        pop(b); chk("R1 last", b, 127);
        chk("R2 empty still stale", empty_o, 0);
        idle();
        chk("R3 released on empty", alarm_o, 0);
        chk("R2 empty after drain", empty_o, 1);
    endtask

    task automatic t_unguarded();
        logic [7:0] b;
        wreg(2'd2, 122);
        wreg(2'd0, 32'h0000_2407);
        for (int i = 0; i < 122; i++) push(8'(i));
        idle(); chk("R4 gran 7 never asserts", alarm_o, 0);
        wreg(2'd0, 32'h0000_2406);
        idle(); chk("R4 gran 6 asserts", alarm_o, 1);
        for (int i = 0; i < 122; i++) pop(b);
        idle();
        wreg(2'd0, 32'h0000_2401);
    endtask

    task automatic t_overflow();
        logic [7:0] b;
        logic [31:0] v;
        for (int i = 0; i < 128; i++) push(8'(i + 16));
        chk("R6 no error before", err_o, 0);
        push(8'hEE);
        rreg(2'd1, v); chk("R6 overflow bit", v[4], 1);
        chk("R5 overflow unmasked", err_o, 1);
        wr_en = 1'b1; wr_data = 8'hDD; rd_en = 1'b1; b = rd_data;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        chk("R6 read beside dropped write", b, 16);
        for (int i = 1; i < 128; i++) begin
            pop(b);
            chk("R6 contents kept", b, 32'(i + 16));
        end
        chk("R1 zero when empty", rd_data, 0);
        wreg(2'd1, 32'h10);
        chk("R8 w1c overflow", err_o, 0);
    endtask

    task automatic t_underflow();
        logic [7:0] b;
        logic [31:0] v;
        pop(b);
        rreg(2'd1, v); chk("R7 underflow bit", v[3], 1);
        idle(); chk("R7 still empty", empty_o, 1);
        push(8'h5A); pop(b); chk("R7 pointers intact", b, 8'h5A);
        link_flags = 4'b0001; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h9;
        @(negedge clk); reg_we = 1'b0; link_flags = '0;
        rreg(2'd1, v); chk("R8 set wins over clear", v[5:0], 6'h01);
        wreg(2'd1, 32'h3F);
        rreg(2'd1, v); chk("R8 all cleared", v[5:0], 0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        link_flags = 4'b1100;
        @(negedge clk); link_flags = '0;
        rreg(2'd1, v); chk("R8 link flags map", v[5:0], 6'b100100);
        chk("R5 masked sources", err_o, 0);
        wreg(2'd0, 32'h0000_0401);
        chk("R5 unmasked transmit wait", err_o, 1);
        wreg(2'd0, 32'h0000_2401);
        chk("R5 remasked", err_o, 0);
        wreg(2'd1, 32'h3F);
        link_flags = 4'b0010; @(negedge clk); link_flags = '0;
        chk("R5 frame accept unmasked", err_o, 1);
        wreg(2'd0, 32'h0000_2601);
        chk("R5 frame accept masked", err_o, 0);
        wreg(2'd1, 32'h3F);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        logic [7:0] b;
        wreg(2'd0, 32'hFFFF_FFFF);
        rreg(2'd0, v); chk("R9 reserved read zero", v, 32'h0001_3F07);
        wreg(2'd0, 32'h0001_2401);
        wreg(2'd2, 2);
        push(8'hA1); push(8'hA2);
        idle(); chk("R10 frame mark no effect", alarm_o, 1);
        pop(b); chk("R10 data unchanged", b, 8'hA1);
        pop(b); chk("R10 data unchanged 2", b, 8'hA2);
        rreg(2'd0, v); chk("R10 frame mark stored", v[16], 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alarm();
        t_unguarded();
        t_overflow();
        t_underflow();
        t_masks();
        t_ctrl();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule